// File: doc/BRIEF.md
# DSP Host Memory Window

This block is the host-side access window into the local storage of an embedded signal processor. A host bus with 16-bit registers loads a 32-bit window address in two halves. It then moves words through data ports, and the block turns each host access into one cycle on a simple synchronous memory port. Data-store words are 16 bits wide. Instruction-store words are 32 bits wide and are told apart by a single address bit. An instruction word is transferred as a low half followed by a high half.

A bridge control register can make the window address advance after each access, so a block transfer needs only one address load. A separate read-and-clear port returns a word and zeroes that location in the same access. A pending register collects interrupt requests from the processor side. The host reads this register, then clears the bits it has handled by writing their complement. The interrupt line to the host is gated by an enable bit.

Host registers are selected by `host_sel`: 0 address bits 15:0, 1 address bits 31:16, 2 common data port, 3 instruction low-half port, 4 read-and-clear port, 5 bridge control, 6 interrupt pending. A host read returns data on `host_rdata` in the same cycle. All side effects take place at the clock edge that ends the access.

Top module: `dsp_host_window`

## Requirements
- R1: A write to select 0 sets window address bits 15:0. A write to select 1 sets bits 31:16. Reading either select returns the current half of the address, and `mem_addr` always shows the full window address.
- R2: For an address with bit 22 clear (a data location), a write to select 2 stores `{16'h0, host_wdata}` at the window address. A read of select 2 returns bits 15:0 of the stored word.
- R3: When control bit 1 (memory auto-increment) is 1, each access to select 2, and each read of select 4, advances the window address after the access. The step is 1 for a data location and 4 for an instruction location (bit 22 set).
- R4: When control bit 1 is 0, the window address never changes except through writes to select 0 or 1, so repeated accesses hit the same location.
- R5: A write to select 3 only captures a staging half-word and causes no memory write and no address advance. A later write to select 2 at an instruction location then stores `{host_wdata, staged half}` as one 32-bit word.
- R6: At an instruction location, a read of select 3 returns word bits 15:0 and does not advance the address. A read of select 2 returns word bits 31:16.
- R7: A read of select 4 returns bits 15:0 of the addressed word and writes zero to that location in the same cycle.
- R8: The control register at select 5 resets to 0. Its bits are: 0 interrupt enable, 1 memory auto-increment, 2 I/O auto-increment, 3 diagnostic mode. It reads back as written, with bits 15:4 read as zero.
- R9: Each bit set on `dsp_irq_set` in a cycle sets the matching pending bit. A read of select 6 returns the pending bits. A write to select 6 clears each pending bit where the written value is 0 and leaves it unchanged where the value is 1.
- R10: A pending bit set from `dsp_irq_set` in the same cycle as a host clear of that bit stays set.
- R11: `irq_out` is 1 exactly when control bit 0 is 1 and at least one pending bit is 1.
- R12: After reset the address, control, pending and staging registers are 0, `irq_out` is 0, and `mem_we` is 0 while the host is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_sel | input | 3 | Host register select |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid in the strobe cycle |
| mem_addr | output | 32 | Memory address (the window address) |
| mem_wdata | output | 32 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 32 | Memory read data for `mem_addr`, same cycle |
| dsp_irq_set | input | NSRC | Interrupt set pulses from the processor side |
| irq_out | output | 1 | Interrupt to the host |

## Verification
Directed block transfers are run with auto-increment on and then off. Comparing the address read back after each run shows step-by-one, step-by-four and hold behaviour, so each can be told apart. Instruction words are written and read as split halves. Each half is placed in a distinct pattern, which shows whether the halves are swapped, lost from staging, or followed by an early address advance. The interrupt register is driven with complement-write clears. In one of these writes a set pulse collides with the clear, which separates set-priority from clear-priority. After these directed cases, a seeded random mix of every register access is checked against a reference memory and register model kept in the bench.

// File: rtl/dshw_pkg.sv
package dshw_pkg;
  typedef enum logic [2:0] {
    SEL_ALO = 3'd0,
    SEL_AHI = 3'd1,
    SEL_DAT = 3'd2,
    SEL_ILO = 3'd3,
    SEL_RAC = 3'd4,
    SEL_CTL = 3'd5,
    SEL_IRQ = 3'd6,
    SEL_RSV = 3'd7
  } host_sel_e;

  typedef struct packed {
    logic diag;
    logic io_inc;
    logic mem_inc;
    logic irq_en;
  } bridge_ctl_t;

  // Address after one stepping access.
  function automatic logic [31:0] step_addr(input logic [31:0] a, input logic instr);
    return a + (instr ? 32'd4 : 32'd1);
  endfunction

  // Word placed on the memory port for a common-port or clearing access.
  function automatic logic [31:0] pack_word(input logic instr, input logic clr,
                                            input logic [15:0] hi, input logic [15:0] lo);
    if (clr)        return 32'h0;
    else if (instr) return {hi, lo};
    else            return {16'h0, hi};
  endfunction
endpackage

// File: rtl/dshw_addr_ctr.sv
module dshw_addr_ctr #(
  parameter int ISTORE_BIT = 22
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ld_lo,
  input  logic        ld_hi,
  input  logic [15:0] wdata,
  input  logic        step_ev,
  output logic [31:0] addr,
  output logic        is_instr
);
  import dshw_pkg::*;
  logic [31:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst)          addr_q <= '0;
    else if (ld_lo)   addr_q[15:0]  <= wdata;
    else if (ld_hi)   addr_q[31:16] <= wdata;
    else if (step_ev) addr_q <= step_addr(addr_q, addr_q[ISTORE_BIT]);
  end

  assign addr     = addr_q;
  assign is_instr = addr_q[ISTORE_BIT];
endmodule

// File: rtl/dshw_irq_pend.sv
module dshw_irq_pend #(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_wr,
  input  logic [NSRC-1:0] keep_mask,
  input  logic [NSRC-1:0] set,
  output logic [NSRC-1:0] pend
);
  logic [NSRC-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst)         pend_q <= '0;
    else if (clr_wr) pend_q <= (pend_q & keep_mask) | set;
    else             pend_q <= pend_q | set;
  end

  assign pend = pend_q;
endmodule

// File: rtl/dshw_xfer.sv
module dshw_xfer (
  input  logic                clk,
  input  logic                rst,
  input  dshw_pkg::host_sel_e sel,
  input  logic                wr,
  input  logic                rd,
  input  logic [15:0]         wdata,
  input  logic                is_instr,
  input  logic                mem_inc,
  input  logic [31:0]         mem_rdata,
  output logic                mem_we,
  output logic [31:0]         mem_wdata,
  output logic                step_ev,
  output logic [15:0]         data_rd
);
  import dshw_pkg::*;
  logic [15:0] stage_q;
  logic        dat_acc, rac_rd, ilo_wr;

  assign dat_acc = (wr || rd) && (sel == SEL_DAT);
  assign rac_rd  = rd && (sel == SEL_RAC);
  assign ilo_wr  = wr && (sel == SEL_ILO);

  always_ff @(posedge clk) begin
    if (rst)         stage_q <= '0;
    else if (ilo_wr) stage_q <= wdata;
  end

  assign mem_we    = (wr && (sel == SEL_DAT)) || rac_rd;
  assign mem_wdata = pack_word(is_instr, rac_rd, wdata, stage_q);
  assign step_ev   = mem_inc && (dat_acc || rac_rd);

  always_comb begin
    data_rd = mem_rdata[15:0];
    if (sel == SEL_DAT && is_instr) data_rd = mem_rdata[31:16];
  end
endmodule

// File: rtl/dsp_host_window.sv
module dsp_host_window #(
  parameter int NSRC       = 16,
  parameter int ISTORE_BIT = 22
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      host_sel,
  input  logic            host_wr,
  input  logic            host_rd,
  input  logic [15:0]     host_wdata,
  output logic [15:0]     host_rdata,
  output logic [31:0]     mem_addr,
  output logic [31:0]     mem_wdata,
  output logic            mem_we,
  input  logic [31:0]     mem_rdata,
  input  logic [NSRC-1:0] dsp_irq_set,
  output logic            irq_out
);
  import dshw_pkg::*;

  host_sel_e       sel;
  bridge_ctl_t     ctl_q;
  logic [31:0]     win_addr;
  logic            is_instr, step_ev;
  logic [15:0]     data_rd, pend_ext, ctl_ext;
  logic [NSRC-1:0] pend;
  logic            irq_en_w, mem_inc_w;

  assign sel       = host_sel_e'(host_sel);
  assign irq_en_w  = ctl_q.irq_en;
  assign mem_inc_w = ctl_q.mem_inc;

  always_ff @(posedge clk) begin
    if (rst)                               ctl_q <= '0;
    else if (host_wr && sel == SEL_CTL)    ctl_q <= bridge_ctl_t'(host_wdata[3:0]);
  end

  dshw_addr_ctr #(.ISTORE_BIT(ISTORE_BIT)) addr_i (
    .clk(clk), .rst(rst),
    .ld_lo(host_wr && sel == SEL_ALO),
    .ld_hi(host_wr && sel == SEL_AHI),
    .wdata(host_wdata), .step_ev(step_ev),
    .addr(win_addr), .is_instr(is_instr)
  );

  dshw_xfer xfer_i (
    .clk(clk), .rst(rst), .sel(sel), .wr(host_wr), .rd(host_rd),
    .wdata(host_wdata), .is_instr(is_instr), .mem_inc(mem_inc_w),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .step_ev(step_ev), .data_rd(data_rd)
  );

  dshw_irq_pend #(.NSRC(NSRC)) pend_i (
    .clk(clk), .rst(rst),
    .clr_wr(host_wr && sel == SEL_IRQ),
    .keep_mask(host_wdata[NSRC-1:0]),
    .set(dsp_irq_set), .pend(pend)
  );

  always_comb begin
    pend_ext = '0;
    pend_ext[NSRC-1:0] = pend;
    ctl_ext = {12'h0, ctl_q};
  end

  always_comb begin
    case (sel)
      SEL_ALO:                   host_rdata = win_addr[15:0];
      SEL_AHI:                   host_rdata = win_addr[31:16];
      SEL_DAT, SEL_ILO, SEL_RAC: host_rdata = data_rd;
      SEL_CTL:                   host_rdata = ctl_ext;
      SEL_IRQ:                   host_rdata = pend_ext;
      default:                   host_rdata = '0;
    endcase
  end

  assign mem_addr = win_addr;
  assign irq_out  = ctl_q.irq_en && (|pend);
endmodule

// File: rtl/dshw_checker.sv
module dshw_checker #(
  parameter int NSRC = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      host_sel,
  input logic            host_wr,
  input logic            host_rd,
  input logic [31:0]     mem_addr,
  input logic [31:0]     mem_wdata,
  input logic            mem_we,
  input logic [NSRC-1:0] dsp_irq_set,
  input logic            irq_out,
  input logic            step_ev,
  input logic            is_instr,
  input logic            irq_en_w,
  input logic            mem_inc_w
);
  logic addr_ld;
  assign addr_ld = host_wr && (host_sel == 3'd0 || host_sel == 3'd1);

  a_r3_data_step: assert property (@(posedge clk) disable iff (rst)
    (step_ev && !is_instr) |=> (mem_addr == $past(mem_addr) + 32'd1));

  a_r3_instr_step: assert property (@(posedge clk) disable iff (rst)
    (step_ev && is_instr) |=> (mem_addr == $past(mem_addr) + 32'd4));

  a_r4_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (!mem_inc_w && !addr_ld) |=> $stable(mem_addr));

  a_r5_low_no_write: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_sel == 3'd3) |-> (!mem_we && !step_ev));

  a_r7_clear_zero: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_sel == 3'd4) |-> (mem_we && mem_wdata == 32'h0));

  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    (irq_en_w && (|dsp_irq_set) && !(host_wr && host_sel == 3'd5)) |=> irq_out);

  a_r11_gated: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> irq_en_w);
endmodule

bind dsp_host_window dshw_checker #(.NSRC(NSRC)) chk_i (
  .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
  .dsp_irq_set(dsp_irq_set), .irq_out(irq_out), .step_ev(step_ev),
  .is_instr(is_instr), .irq_en_w(irq_en_w), .mem_inc_w(mem_inc_w)
);

// File: tb/dsp_host_window_tb_top.sv
module dsp_host_window_tb_top;
  logic        clk = 0;
  logic        rst;
  logic [2:0]  host_sel = 0;
  logic        host_wr = 0, host_rd = 0;
  logic [15:0] host_wdata = 0;
  logic [15:0] host_rdata;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;
  logic [15:0] dsp_irq_set = 0;
  logic        irq_out;

  int checks = 0, errors = 0;

  // bench memory and reference model
  logic [31:0] bmem [512];
  logic [31:0] rmem [512];
  logic [31:0] ea;
  logic [3:0]  ec;
  logic [15:0] ep, es;

  always #5 clk = ~clk;

  dsp_host_window dut_i (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
    .dsp_irq_set(dsp_irq_set), .irq_out(irq_out)
  );

  function automatic int midx(input logic [31:0] a);
    return {23'h0, a[22], a[7:0]};
  endfunction

  always_comb mem_rdata = bmem[midx(mem_addr)];
  always @(posedge clk) if (mem_we) bmem[midx(mem_addr)] <= mem_wdata;

  // expected address after a stepping access
  function automatic logic [31:0] nxt(input logic [31:0] a);
    if (!ec[1]) return a;
    return a[22] ? a + 32'h4 : a + 32'h1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [2:0] s, input logic [15:0] d,
                     input logic [15:0] set, output logic [15:0] rd);
    @(negedge clk);
    host_wr = w; host_rd = !w; host_sel = s; host_wdata = d; dsp_irq_set = set;
    #1 rd = host_rdata;
    @(posedge clk);
    #1;
    host_wr = 0; host_rd = 0; dsp_irq_set = 0;
  endtask

  task automatic op_wr(input logic [2:0] s, input logic [15:0] d, input logic [15:0] set);
    logic [15:0] rd;
    int k;
    k = midx(ea);
    acc(1'b1, s, d, set, rd);
    case (s)
      3'd0: ea[15:0] = d;
      3'd1: ea[31:16] = d;
      3'd2: begin
        rmem[k] = ea[22] ? {d, es} : {16'h0, d};
        chk(ea[22] ? "R5 word" : "R2 word", bmem[k], rmem[k]);
        ea = nxt(ea);
      end
      3'd3: es = d;
      3'd5: ec = d[3:0];
      3'd6: ep = ep & d;
      default: ;
    endcase
    ep = ep | set;
    chk("R11 irq", {31'h0, irq_out}, {31'h0, ec[0] & (|ep)});
  endtask

  task automatic op_rd(input logic [2:0] s, input logic [15:0] set, input string tag);
    logic [15:0] rd, ex;
    int k;
    k = midx(ea);
    acc(1'b0, s, 16'h0, set, rd);
    case (s)
      3'd0: ex = ea[15:0];
      3'd1: ex = ea[31:16];
      3'd2: ex = ea[22] ? rmem[k][31:16] : rmem[k][15:0];
      3'd3: ex = rmem[k][15:0];
      3'd4: ex = rmem[k][15:0];
      3'd5: ex = {12'h0, ec};
      3'd6: ex = ep;
      default: ex = 16'h0;
    endcase
    chk(tag, {16'h0, rd}, {16'h0, ex});
    if (s == 3'd4) begin
      rmem[k] = 32'h0;
      chk("R7 cleared", bmem[k], 32'h0);
    end
    if (s == 3'd2 || s == 3'd4) ea = nxt(ea);
    ep = ep | set;
    chk("R11 irq", {31'h0, irq_out}, {31'h0, ec[0] & (|ep)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 512; i++) begin bmem[i] = 0; rmem[i] = 0; end
    ea = 0; ec = 0; ep = 0; es = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;

    // R12 reset state
    #2;
    chk("R12 mem_we idle", {31'h0, mem_we}, 32'h0);
    chk("R12 irq_out", {31'h0, irq_out}, 32'h0);
    op_rd(3'd0, 0, "R12 addr lo");
    op_rd(3'd1, 0, "R12 addr hi");
    op_rd(3'd5, 0, "R12 ctrl");
    op_rd(3'd6, 0, "R12 pending");

    // R1 address load
    op_wr(3'd1, 16'h1234, 0);
    op_rd(3'd1, 0, "R1 addr hi");
    chk("R1 mem_addr", mem_addr, 32'h1234_0000);
    op_wr(3'd1, 16'h0000, 0);
    op_wr(3'd0, 16'h0010, 0);
    op_rd(3'd0, 0, "R1 addr lo");

    // R8 control
    op_wr(3'd5, 16'hFFFA, 0);
    op_rd(3'd5, 0, "R8 ctrl readback");

    // R2/R3 data block with auto-increment
    op_wr(3'd5, 16'h0002, 0);
    op_wr(3'd2, 16'hA001, 0);
    op_wr(3'd2, 16'hA002, 0);
    op_wr(3'd2, 16'hA003, 0);
    op_rd(3'd0, 0, "R3 step by one");
    op_wr(3'd0, 16'h0010, 0);
    op_rd(3'd2, 0, "R2 read 0");
    op_rd(3'd2, 0, "R2 read 1");
    op_rd(3'd2, 0, "R2 read 2");

    // R4 no auto-increment
    op_wr(3'd5, 16'h0000, 0);
    op_wr(3'd0, 16'h0020, 0);
    op_wr(3'd2, 16'h5555, 0);
    op_wr(3'd2, 16'h6666, 0);
    op_rd(3'd2, 0, "R4 same location");
    op_rd(3'd2, 0, "R4 same location again");
    op_rd(3'd0, 0, "R4 address held");

    // R5/R6 instruction words
    op_wr(3'd5, 16'h0002, 0);
    op_wr(3'd1, 16'h0040, 0);
    op_wr(3'd0, 16'h0014, 0);
    op_wr(3'd3, 16'h1111, 0);
    op_rd(3'd0, 0, "R5 no step on low half");
    op_wr(3'd2, 16'h2222, 0);
    op_rd(3'd0, 0, "R3 step by four");
    op_wr(3'd3, 16'h3333, 0);
    op_wr(3'd2, 16'h4444, 0);
    op_wr(3'd0, 16'h0014, 0);
    op_rd(3'd3, 0, "R6 low half");
    op_rd(3'd0, 0, "R6 low read no step");
    op_rd(3'd2, 0, "R6 high half");
    op_rd(3'd3, 0, "R6 second low half");
    op_rd(3'd2, 0, "R6 second high half");

    // R7 read-and-clear
    op_wr(3'd1, 16'h0000, 0);
    op_wr(3'd0, 16'h0010, 0);
    op_rd(3'd4, 0, "R7 returns word");
    op_wr(3'd0, 16'h0010, 0);
    op_rd(3'd2, 0, "R7 location now zero");

    // R9/R10/R11 interrupts
    op_wr(3'd5, 16'h0003, 0);
    op_rd(3'd5, 16'h0005, "R8 ctrl");
    op_rd(3'd6, 0, "R9 pending read");
    op_wr(3'd6, ~16'h0005, 0);
    op_rd(3'd6, 0, "R9 cleared");
    op_rd(3'd5, 16'h000C, "R8 ctrl");
    op_wr(3'd6, 16'hFFFB, 0);
    op_rd(3'd6, 0, "R9 partial clear");
    op_wr(3'd6, 16'h0000, 16'h0008);
    op_rd(3'd6, 0, "R10 set beats clear");
    op_wr(3'd5, 16'h0002, 0);
    chk("R11 gated off", {31'h0, irq_out}, 32'h0);
    op_wr(3'd6, 16'h0000, 0);

    // seeded random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] d, st;
      d  = 16'($urandom);
      st = (($urandom % 4) == 0) ? 16'($urandom) : 16'h0;
      case ($urandom % 12)
        0: op_wr(3'd0, d & 16'h00FF, st);
        1: op_wr(3'd1, ($urandom % 2) ? 16'h0040 : 16'h0000, st);
        2, 3: op_wr(3'd2, d, st);
        4: op_wr(3'd3, d, st);
        5, 6: op_rd(3'd2, st, "R2 random read");
        7: op_rd(3'd3, st, "R6 random low read");
        8: op_rd(3'd4, st, "R7 random clear read");
        9: op_wr(3'd5, d & 16'h000F, st);
        10: op_wr(3'd6, d, st);
        default: op_rd(3'd6, st, "R9 random pending read");
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule